// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects 32 peripheral interrupt lines and presents them to a processor core as two request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line is synchronized to the block clock. Per-source configuration sets four things: whether the line is active high or active low, whether it is edge or level detected, whether it is enabled, and which of the two outputs it drives.

Among the enabled, pending sources that are routed to the normal output, a priority encoder picks a winner. The priority is a 4-bit value programmed per source. Software reads the winner's index from a vector register, and bit 31 of that register flags that nothing valid is pending. When the clear-on-read control bit is set, the read also clears the latched pending state of the reported source. This allows an interrupt handler to fetch and acknowledge an interrupt with a single bus access.

All configuration is reached through a simple single-cycle register bus. Read data appears on `rdata_o` one clock after the read request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every configuration register reads zero, `irq_o` and `fiq_o` are low, and a vector read returns 32'h8000_0000.
- R2: Source i contributes to the outputs and to the vector only while bit i of the enable register (address 0) is set.
- R3: Bit i of the route register (address 1) set sends source i to `irq_o`; clear sends it to `fiq_o`. FIQ-routed sources never appear in the vector.
- R4: Bit i of the polarity register (address 2) set makes source i active low; clear makes it active high.
- R5: Bit i of the mode register (address 3) set makes source i level detected, pending only while its synchronized input is active. Clear makes it edge detected: an inactive-to-active transition latches a pending bit that stays set after the input returns inactive.
- R6: Priorities sit at addresses 4 to 7. Source i uses bits [4*(i%8)+3 : 4*(i%8)] of address 4+i/8. The lowest value wins, and on equal values the lowest source index wins.
- R7: A read of the vector register (address 10) returns the winning index in bits [4:0] with bit 31 clear. If no enabled IRQ-routed source is pending, it returns 32'h8000_0000.
- R8: With control bit 31 (address 8) set, a vector read clears the latched pending bit of the reported edge source. A level source stays pending while its input is active. With the bit clear, reads change nothing.
- R9: Global mask register (address 9): bit 0 gates `irq_o` and bit 1 gates `fiq_o`.
- R10: Outputs are registered. A level input that turns active is seen by `irq_o` three cycles later: two synchronizer stages plus the output register. A new edge on a source in the same cycle as a read that clears it leaves the source pending.
- R11: Every configuration register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt source lines |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when set, read when clear |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can act on the same edge-source pending bit in one cycle: a clearing vector read of that source, and a fresh active edge arriving on it. The bench first latches source 5. It then raises the input again, timed so that the synchronized edge is detected in exactly the cycle the vector read is sampled. The read must report 5, and a second read must still report 5, which shows the new edge won over the clear. A final read after the line has gone quiet must clear it as usual.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_EN    = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_POL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PRIO0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_GMASK = 4'd9;
  localparam logic [ADDR_W-1:0] A_VEC   = 4'd10;
endpackage

// File: rtl/ivc_src.sv
module ivc_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic level_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic act, act_q, rise, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};

  assign act  = sync_q[SYNC_STAGES-1] ^ pol_i;
  assign rise = act & ~act_q;

  // set beats clear so a coincident new edge is not lost
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      act_q <= act;
      if (level_i)   edge_q <= 1'b0;
      else if (rise) edge_q <= 1'b1;
      else if (clr_i) edge_q <= 1'b0;
    end

  assign pend_o = level_i ? act : edge_q;

  assert_edge_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !level_i) |=> edge_q);
  assert_edge_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !edge_q);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && rise && !level_i) |=> edge_q);
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
  parameter int N      = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        cand_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [PRIO_W-1:0] best;

  // scan high to low with <= so ties settle on the lowest index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        valid_o = 1'b1;
        idx_o   = i[IDX_W-1:0];
        best    = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  logic [PRIO_W-1:0] win_prio;
  assign win_prio = prio_i[int'(idx_o)*PRIO_W +: PRIO_W];

  assert_winner_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[idx_o]);
  assert_none_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cand_i == '0));

  for (genvar j = 0; j < N; j++) begin : g_order
    assert_prio_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && cand_i[j]) |->
        (win_prio < prio_i[j*PRIO_W +: PRIO_W]) ||
        (win_prio == prio_i[j*PRIO_W +: PRIO_W] && idx_o <= IDX_W'(j)));
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int IDX_W      = $clog2(N_SRC);
  localparam int PRIO_WORDS = N_SRC * PRIO_W / DATA_W;
  localparam logic [DATA_W-1:0] VEC_NONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [N_SRC-1:0]  en_q, sel_q, pol_q, mode_q;
  logic [DATA_W-1:0] prio_q [PRIO_WORDS];
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic              clr_rd_q;
  logic [1:0]        gmask_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic wr, rd, vec_rd;
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign vec_rd = rd && addr_i == A_VEC;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q <= '0; sel_q <= '0; pol_q <= '0; mode_q <= '0;
      clr_rd_q <= 1'b0; gmask_q <= '0;
      for (int w = 0; w < PRIO_WORDS; w++) prio_q[w] <= '0;
    end else if (wr) begin
      if (addr_i == A_EN)    en_q     <= wdata_i[N_SRC-1:0];
      if (addr_i == A_SEL)   sel_q    <= wdata_i[N_SRC-1:0];
      if (addr_i == A_POL)   pol_q    <= wdata_i[N_SRC-1:0];
      if (addr_i == A_MODE)  mode_q   <= wdata_i[N_SRC-1:0];
      if (addr_i == A_CTRL)  clr_rd_q <= wdata_i[DATA_W-1];
      if (addr_i == A_GMASK) gmask_q  <= wdata_i[1:0];
      for (int w = 0; w < PRIO_WORDS; w++)
        if (addr_i == ADDR_W'(int'(A_PRIO0) + w)) prio_q[w] <= wdata_i;
    end

  always_comb
    for (int w = 0; w < PRIO_WORDS; w++) prio_flat[w*DATA_W +: DATA_W] = prio_q[w];

  // per-source detection
  logic [N_SRC-1:0] pend, clr;
  logic             arb_valid;
  logic [IDX_W-1:0] arb_idx;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign clr[i] = vec_rd & clr_rd_q & arb_valid & (arb_idx == IDX_W'(i));
    ivc_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk_i, .rst_ni,
      .src_i  (src_i[i]),
      .pol_i  (pol_q[i]),
      .level_i(mode_q[i]),
      .clr_i  (clr[i]),
      .pend_o (pend[i])
    );
  end

  logic [N_SRC-1:0] irq_cand, fiq_cand;
  assign irq_cand = pend & en_q & sel_q;
  assign fiq_cand = pend & en_q & ~sel_q;

  ivc_arb #(.N(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni,
    .cand_i (irq_cand),
    .prio_i (prio_flat),
    .valid_o(arb_valid),
    .idx_o  (arb_idx)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_EN)    rd_mux = DATA_W'(en_q);
    if (addr_i == A_SEL)   rd_mux = DATA_W'(sel_q);
    if (addr_i == A_POL)   rd_mux = DATA_W'(pol_q);
    if (addr_i == A_MODE)  rd_mux = DATA_W'(mode_q);
    if (addr_i == A_CTRL)  rd_mux = {clr_rd_q, {(DATA_W-1){1'b0}}};
    if (addr_i == A_GMASK) rd_mux = DATA_W'(gmask_q);
    if (addr_i == A_VEC)   rd_mux = arb_valid ? DATA_W'(arb_idx) : VEC_NONE;
    for (int w = 0; w < PRIO_WORDS; w++)
      if (addr_i == ADDR_W'(int'(A_PRIO0) + w)) rd_mux = prio_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      irq_o <= gmask_q[0] & (|irq_cand);
      fiq_o <= gmask_q[1] & (|fiq_cand);
    end

  assign rdata_o = rdata_q;

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gmask_q[0] |=> !irq_o);
  assert_fiq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gmask_q[1] |=> !fiq_o);
  assert_irq_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask_q[0] && (|(pend & en_q & sel_q))) |=> irq_o);
  assert_disabled_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> (!irq_o && !fiq_o));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  import ivc_pkg::*;

  localparam logic [31:0] NONE = 32'h8000_0000;
  // {source pattern, expected vector}; priority of source i = 15 - (i % 16)
  localparam logic [63:0] TBL [8] = '{
    {32'h0000_0000, NONE},
    {32'h0000_0001, 32'd0},
    {32'h0000_0003, 32'd1},
    {32'h8000_8000, 32'd15},
    {32'h8000_0008, 32'd31},
    {32'hFFFF_FFFF, 32'd15},
    {32'h0001_0001, 32'd0},
    {32'h00FF_0000, 32'd23}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, fiq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // callers are at a negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 fiq_o", 32'(fiq), 0);
    rd(A_VEC, v);  chk("R1 vector", v, NONE);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    rd(A_GMASK, v); chk("R1 gmask", v, 0);

    // R11 readback
    wr(A_POL, 32'hA5A5_0000); rd(A_POL, v); chk("R11 pol", v, 32'hA5A5_0000);
    wr(A_POL, 0);
    wr(A_CTRL, 32'h8000_0000); rd(A_CTRL, v); chk("R11 ctrl", v, 32'h8000_0000);
    wr(A_CTRL, 0);

    // table setup: all enabled, IRQ-routed, level, active high
    wr(A_EN, '1); wr(A_SEL, '1); wr(A_MODE, '1); wr(A_GMASK, 32'd3);
    wr(4'd4, 32'h89AB_CDEF); wr(4'd5, 32'h0123_4567);
    wr(4'd6, 32'h89AB_CDEF); wr(4'd7, 32'h0123_4567);
    rd(4'd5, v); chk("R11 prio", v, 32'h0123_4567);

    for (int k = 0; k < 8; k++) begin
      src = TBL[k][63:32];
      idle(4);
      rd(A_VEC, v);
      chk("R6/R7 vector", v, TBL[k][31:0]);
      chk("R3 irq_o", 32'(irq), 32'(|TBL[k][63:32]));
    end

    // R4 polarity
    src = '0; idle(4);
    wr(A_POL, 32'h4); idle(4);
    rd(A_VEC, v); chk("R4 active low", v, 32'd2);
    wr(A_POL, 0); idle(4);
    rd(A_VEC, v); chk("R4 restored", v, NONE);

    // R2 enable
    src = 32'h80; wr(A_EN, ~32'h80); idle(4);
    rd(A_VEC, v); chk("R2 masked vector", v, NONE);
    chk("R2 masked irq", 32'(irq), 0);
    wr(A_EN, '1); idle(3);
    rd(A_VEC, v); chk("R2 unmasked", v, 32'd7);

    // R3 routing to FIQ
    wr(A_SEL, ~32'h80); idle(3);
    chk("R3 fiq_o", 32'(fiq), 1);
    chk("R3 irq_o off", 32'(irq), 0);
    rd(A_VEC, v); chk("R3 fiq not in vector", v, NONE);
    // R9 global mask
    wr(A_GMASK, 32'd1); idle(2);
    chk("R9 fiq masked", 32'(fiq), 0);
    wr(A_GMASK, 32'd3); wr(A_SEL, '1); idle(2);
    wr(A_GMASK, 32'd2); idle(2);
    chk("R9 irq masked", 32'(irq), 0);
    wr(A_GMASK, 32'd3); src = '0; idle(4);

    // R10 latency
    src[9] = 1'b1;
    idle(2); chk("R10 irq early", 32'(irq), 0);
    idle(1); chk("R10 irq at 3", 32'(irq), 1);
    src = '0; idle(4);

    // R5 edge latch
    wr(A_MODE, ~32'h20); idle(4);
    src[5] = 1'b1; idle(1); src[5] = 1'b0; idle(4);
    rd(A_VEC, v); chk("R5 edge latched", v, 32'd5);
    rd(A_VEC, v); chk("R8 no clear when off", v, 32'd5);

    // R8 clear on read
    wr(A_CTRL, 32'h8000_0000);
    rd(A_VEC, v); chk("R8 read reports", v, 32'd5);
    rd(A_VEC, v); chk("R8 cleared", v, NONE);
    src[9] = 1'b1; idle(4);
    rd(A_VEC, v); chk("R8 level read", v, 32'd9);
    rd(A_VEC, v); chk("R8 level persists", v, 32'd9);
    src = '0; idle(4);
    rd(A_VEC, v); chk("R5 level gone", v, NONE);

    // R10 edge coincides with clearing read
    src[5] = 1'b1; idle(1); src[5] = 1'b0; idle(4);
    src[5] = 1'b1; idle(2);
    rd(A_VEC, v); chk("R10 collide read", v, 32'd5);
    rd(A_VEC, v); chk("R10 set wins", v, 32'd5);
    src = '0; idle(4);
    rd(A_VEC, v); chk("R10 later clear", v, NONE);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule